// File: doc/BRIEF.md
# Power Register Access Command Engine

This engine sits on the controller side of a host-to-controller mailbox. When the doorbell pulses it looks at the message type, sub-command and size fields of the command word. If the type is the power-control type, it walks the outbound data buffer and turns each item into an access on an 8-bit register space, using a simple synchronous register port. Read results go into the inbound buffer one byte at a time. When the last access or inbound write has finished, the engine pulses done with an error flag and a code.

There are three sub-commands: a list of byte writes, a list of byte reads, and a masked read-modify-write of a single register. Each carries its own rule for the size field. A transaction carries at most five items. A command that breaks a rule completes at once with an error code and makes no register access. The mailbox holds the outbound buffer steady from the doorbell until done.

Top module: `pwr_cmd_engine`

## Requirements
- R1: The message type is `db_type` (8 bits). A doorbell with any type other than 0xFF completes with done in the next cycle, `err`=1 and `err_code`=3, and makes no register access. This check has priority over R2 and R3.
- R2: The sub-command is `db_sub` (4 bits): 0 is write, 1 is read and 2 is read-modify-write. With type 0xFF, any other value completes in the next cycle with `err_code`=2 and no access. This check has priority over R3.
- R3: The size is `db_size` (8 bits). A write needs size 3n, a read needs 2n, and a read-modify-write needs exactly 4, with n between 1 and 5. A zero size, a size that is not a multiple of the rule, or one that implies more than 5 items completes in the next cycle with `err_code`=1 and no access.
- R4: Address k is little-endian in outbound bytes 2k (low) and 2k+1 (high). For a write, data byte k is outbound byte 2n+k. Items are written in ascending k, one write per cycle, in cycles 1..n after the doorbell edge.
- R5: For a read, item k is read in cycle 2k+1 after the doorbell edge. In the following cycle the returned byte is written to inbound byte k.
- R6: For a read-modify-write, the address is in bytes 0-1, the value in byte 2 and the mask in byte 3. The engine reads the register in cycle 1 and writes back (old & ~mask) | (value & mask) to the same address in cycle 2.
- R7: Done is a one-cycle pulse in the cycle after the last access or inbound write: cycle n+1 for a write, 2n+1 for a read, 3 for a read-modify-write. On success `err`=0 and `err_code`=0. `err` and `err_code` read zero while done is low.
- R8: A doorbell that arrives while a command is in progress is ignored. It causes no access and no extra done.
- R9: After reset the engine is idle, with `reg_en`, `ib_we` and `done` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| db_valid | input | 1 | Doorbell: a command is present for one cycle |
| db_type | input | 8 | Message type of the command |
| db_sub | input | 4 | Sub-command code |
| db_size | input | 8 | Byte count of the outbound data |
| ob_buf | input | OB_BYTES*8 | Outbound buffer; byte i is at bits 8i+7:8i |
| reg_en | output | 1 | Register port access strobe |
| reg_we | output | 1 | Register port write (1) or read (0) |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Read data, valid one cycle after a read strobe |
| ib_we | output | 1 | Inbound buffer byte write strobe |
| ib_idx | output | $clog2(IB_BYTES) | Inbound buffer byte index |
| ib_data | output | 8 | Inbound buffer byte value |
| done | output | 1 | Command completion pulse |
| err | output | 1 | Error flag, valid with done |
| err_code | output | 8 | 0 ok, 1 size, 2 sub-command, 3 message type |

## Verification
Every result the engine produces has a fixed cycle, counted from the clock edge that samples the doorbell. Error completion comes in cycle 1. A write to item k comes in cycle k+1. A read strobe comes in cycle 2k+1, and its inbound byte in cycle 2k+2. The read-modify-write has its read in cycle 1 and its write in cycle 2. Done comes in cycle n+1, 2n+1 or 3. The driver stores each expected event with its absolute cycle number. The monitor samples on falling edges and compares kind, address or index, data and cycle, so an event that comes early, late, out of order or unexpected is reported.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam logic [7:0] PWR_MSG_TYPE = 8'hFF;
  localparam logic [3:0] SUB_WR  = 4'd0;
  localparam logic [3:0] SUB_RD  = 4'd1;
  localparam logic [3:0] SUB_RMW = 4'd2;

  localparam logic [7:0] ERR_NONE = 8'd0;
  localparam logic [7:0] ERR_SIZE = 8'd1;
  localparam logic [7:0] ERR_SUB  = 8'd2;
  localparam logic [7:0] ERR_TYPE = 8'd3;

  typedef enum logic [1:0] {OP_WR, OP_RD, OP_RMW} op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WR, S_RD_ISS, S_RD_CAP, S_RMW_RD, S_RMW_WR, S_DONE
  } state_e;
endpackage

// File: rtl/pce_decode.sv
module pce_decode
  import pce_pkg::*;
#(
  parameter int MAX_ITEMS = 5,
  localparam int CNT_W = $clog2(MAX_ITEMS + 1)
) (
  input  logic [7:0]       msg_type,
  input  logic [3:0]       sub,
  input  logic [7:0]       size,
  output op_e              op,
  output logic [CNT_W-1:0] n_items,
  output logic [7:0]       code
);
  always_comb begin
    op      = OP_WR;
    n_items = '0;
    code    = ERR_NONE;
    if (msg_type != PWR_MSG_TYPE) begin
      code = ERR_TYPE;
    end else begin
      case (sub)
        SUB_WR: begin
          op = OP_WR;
          for (int i = 1; i <= MAX_ITEMS; i++)
            if (int'(size) == 3 * i) n_items = CNT_W'(i);
        end
        SUB_RD: begin
          op = OP_RD;
          for (int i = 1; i <= MAX_ITEMS; i++)
            if (int'(size) == 2 * i) n_items = CNT_W'(i);
        end
        SUB_RMW: begin
          op = OP_RMW;
          if (size == 8'd4) n_items = CNT_W'(1);
        end
        default: code = ERR_SUB;
      endcase
      if (code == ERR_NONE && n_items == '0) code = ERR_SIZE;
    end
  end
endmodule

// File: rtl/pce_seq.sv
module pce_seq
  import pce_pkg::*;
#(
  parameter int MAX_ITEMS = 5,
  parameter int OB_BYTES  = 16,
  parameter int IB_BYTES  = 16,
  localparam int CNT_W    = $clog2(MAX_ITEMS + 1),
  localparam int IB_IDX_W = $clog2(IB_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  db_valid,
  input  op_e                   dec_op,
  input  logic [CNT_W-1:0]      dec_n,
  input  logic [7:0]            dec_code,
  input  logic [OB_BYTES*8-1:0] ob_buf,
  output logic                  reg_en,
  output logic                  reg_we,
  output logic [15:0]           reg_addr,
  output logic [7:0]            reg_wdata,
  input  logic [7:0]            reg_rdata,
  output logic                  ib_we,
  output logic [IB_IDX_W-1:0]   ib_idx,
  output logic [7:0]            ib_data,
  output logic                  done,
  output logic                  err,
  output logic [7:0]            err_code
);
  state_e           state_q, state_d;
  op_e              op_q, op_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, k_q, k_d;
  logic [7:0]       code_q, code_d;
  logic             last_item;

  function automatic logic [7:0] ob_byte(input int unsigned idx);
    return ob_buf[idx*8 +: 8];
  endfunction

  assign last_item = (k_q == cnt_q - CNT_W'(1));

  // next-state logic
  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    cnt_d   = cnt_q;
    k_d     = k_q;
    code_d  = code_q;
    case (state_q)
      S_IDLE: if (db_valid) begin
        op_d   = dec_op;
        cnt_d  = dec_n;
        k_d    = '0;
        code_d = dec_code;
        if (dec_code != ERR_NONE) state_d = S_DONE;
        else begin
          case (dec_op)
            OP_WR:   state_d = S_WR;
            OP_RD:   state_d = S_RD_ISS;
            default: state_d = S_RMW_RD;
          endcase
        end
      end
      S_WR: begin
        if (last_item) state_d = S_DONE;
        else k_d = k_q + CNT_W'(1);
      end
      S_RD_ISS: state_d = S_RD_CAP;
      S_RD_CAP: begin
        if (last_item) state_d = S_DONE;
        else begin
          k_d     = k_q + CNT_W'(1);
          state_d = S_RD_ISS;
        end
      end
      S_RMW_RD: state_d = S_RMW_WR;
      S_RMW_WR: state_d = S_DONE;
      default:  state_d = S_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q    <= OP_WR;
      cnt_q   <= '0;
      k_q     <= '0;
      code_q  <= ERR_NONE;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      cnt_q   <= cnt_d;
      k_q     <= k_d;
      code_q  <= code_d;
    end
  end

  // output decode
  always_comb begin
    int unsigned a_lo;
    a_lo      = 2 * int'(k_q);
    reg_en    = 1'b0;
    reg_we    = 1'b0;
    reg_addr  = {ob_byte(a_lo + 1), ob_byte(a_lo)};
    reg_wdata = '0;
    ib_we     = 1'b0;
    ib_idx    = IB_IDX_W'(k_q);
    ib_data   = reg_rdata;
    done      = 1'b0;
    case (state_q)
      S_WR: begin
        reg_en    = 1'b1;
        reg_we    = 1'b1;
        reg_wdata = ob_byte(2 * int'(cnt_q) + int'(k_q));
      end
      S_RD_ISS, S_RMW_RD: reg_en = 1'b1;
      S_RD_CAP: ib_we = 1'b1;
      S_RMW_WR: begin
        reg_en    = 1'b1;
        reg_we    = 1'b1;
        reg_wdata = (reg_rdata & ~ob_byte(3)) | (ob_byte(2) & ob_byte(3));
      end
      S_DONE: done = 1'b1;
      default: ;
    endcase
  end

  assign err      = done && (code_q != ERR_NONE);
  assign err_code = done ? code_q : ERR_NONE;

  // R7: done never lasts two cycles
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1, R2, R3: a rejected command completes the next cycle with its code
  a_r3_reject_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && db_valid && dec_code != ERR_NONE)
      |=> (done && !reg_en && err_code == $past(dec_code)));
  // R5: an inbound write always follows a read strobe
  a_r5_ib_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    ib_we |-> ($past(reg_en) && !$past(reg_we)));
  // R6: the merged write hits the address read one cycle earlier
  a_r6_rmw_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_we && op_q == OP_RMW)
      |-> ($past(reg_en) && !$past(reg_we) && $past(reg_addr) == reg_addr));
  // R8: a doorbell while busy changes nothing latched
  a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (db_valid && state_q != S_IDLE && state_q != S_DONE)
      |=> ($stable(op_q) && $stable(cnt_q)));
  // R4: access, inbound write and done never overlap
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_en, ib_we, done}));
endmodule

// File: rtl/pwr_cmd_engine.sv
module pwr_cmd_engine
  import pce_pkg::*;
#(
  parameter int MAX_ITEMS = 5,
  parameter int OB_BYTES  = 16,
  parameter int IB_BYTES  = 16,
  localparam int CNT_W    = $clog2(MAX_ITEMS + 1),
  localparam int IB_IDX_W = $clog2(IB_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  db_valid,
  input  logic [7:0]            db_type,
  input  logic [3:0]            db_sub,
  input  logic [7:0]            db_size,
  input  logic [OB_BYTES*8-1:0] ob_buf,
  output logic                  reg_en,
  output logic                  reg_we,
  output logic [15:0]           reg_addr,
  output logic [7:0]            reg_wdata,
  input  logic [7:0]            reg_rdata,
  output logic                  ib_we,
  output logic [IB_IDX_W-1:0]   ib_idx,
  output logic [7:0]            ib_data,
  output logic                  done,
  output logic                  err,
  output logic [7:0]            err_code
);
  op_e              dec_op;
  logic [CNT_W-1:0] dec_n;
  logic [7:0]       dec_code;

  pce_decode #(.MAX_ITEMS(MAX_ITEMS)) u_dec (
    .msg_type(db_type), .sub(db_sub), .size(db_size),
    .op(dec_op), .n_items(dec_n), .code(dec_code)
  );

  pce_seq #(.MAX_ITEMS(MAX_ITEMS), .OB_BYTES(OB_BYTES), .IB_BYTES(IB_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .db_valid(db_valid),
    .dec_op(dec_op), .dec_n(dec_n), .dec_code(dec_code), .ob_buf(ob_buf),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ib_we(ib_we), .ib_idx(ib_idx), .ib_data(ib_data),
    .done(done), .err(err), .err_code(err_code)
  );
endmodule

// File: tb/pwr_cmd_engine_test.sv
module pwr_cmd_engine_test;
  localparam int KRD = 0, KWR = 1, KIB = 2, KDN = 3;

  typedef struct {
    int          kind;
    logic [15:0] a;
    logic [7:0]  d;
    int          cyc;
    string       tag;
  } ev_t;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         db_valid = 1'b0;
  logic [7:0]   db_type = '0, db_size = '0;
  logic [3:0]   db_sub = '0;
  logic [127:0] ob_buf = '0;
  logic         reg_en, reg_we, ib_we, done, err;
  logic [15:0]  reg_addr;
  logic [7:0]   reg_wdata, reg_rdata, ib_data, err_code;
  logic [3:0]   ib_idx;

  int  cyc = 0, t0 = 0, checks = 0, errors = 0;
  ev_t exp_q[$];
  logic [7:0] rmem [256];
  logic [7:0] smem [256];

  pwr_cmd_engine uut (
    .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_type(db_type),
    .db_sub(db_sub), .db_size(db_size), .ob_buf(ob_buf),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ib_we(ib_we), .ib_idx(ib_idx), .ib_data(ib_data),
    .done(done), .err(err), .err_code(err_code)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // register space responder, one-cycle read latency
  initial begin
    for (int i = 0; i < 256; i++) begin
      rmem[i] = 8'(i * 37 + 11);
      smem[i] = 8'(i * 37 + 11);
    end
    reg_rdata = '0;
  end
  always @(posedge clk)
    if (reg_en) begin
      if (reg_we) rmem[reg_addr[7:0]] <= reg_wdata;
      else reg_rdata <= rmem[reg_addr[7:0]];
    end

  task automatic push(input int kind, input logic [15:0] a, input logic [7:0] d,
                      input int off, input string tag);
    ev_t e;
    e.kind = kind; e.a = a; e.d = d; e.cyc = t0 + off; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic observe(input int kind, input logic [15:0] a, input logic [7:0] d);
    ev_t e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL unexpected event kind=%0d a=%h d=%h cyc=%0d (expected none)",
               kind, a, d, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.a != a || e.d != d || e.cyc != cyc) begin
        errors++;
        $display("FAIL %s: got kind=%0d a=%h d=%h cyc=%0d, expected kind=%0d a=%h d=%h cyc=%0d",
                 e.tag, kind, a, d, cyc, e.kind, e.a, e.d, e.cyc);
      end
    end
  endtask

  // monitor
  always @(negedge clk)
    if (rst_n) begin
      if (reg_en) observe(reg_we ? KWR : KRD, reg_addr, reg_we ? reg_wdata : 8'h00);
      if (ib_we) observe(KIB, {12'h000, ib_idx}, ib_data);
      if (done) observe(KDN, {15'h0, err}, err_code);
      else if (err || err_code != 0) observe(KDN, {15'h0, err}, err_code);
    end

  task automatic fire(input logic [7:0] ty, input logic [3:0] sb, input logic [7:0] sz,
                      input logic [127:0] buff, input bit hold);
    int guard;
    db_type = ty; db_sub = sb; db_size = sz; ob_buf = buff; db_valid = 1'b1;
    @(negedge clk);
    if (hold) begin
      db_type = 8'h00;
      @(negedge clk);
    end
    db_valid = 1'b0;
    guard = 0;
    while (!done && guard < 40) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic put16(inout logic [127:0] b, input int pos, input logic [15:0] v);
    b[pos*8 +: 8] = v[7:0];
    b[(pos+1)*8 +: 8] = v[15:8];
  endtask

  task automatic do_write(input logic [15:0] ad [5], input logic [7:0] dt [5], input int n);
    logic [127:0] b = '0;
    t0 = cyc;
    for (int k = 0; k < n; k++) begin
      put16(b, 2*k, ad[k]);
      b[(2*n+k)*8 +: 8] = dt[k];
      push(KWR, ad[k], dt[k], k + 1, "R4 write item");
      smem[ad[k][7:0]] = dt[k];
    end
    push(KDN, 16'h0, 8'h00, n + 1, "R7 write done");
    fire(8'hFF, 4'd0, 8'(3*n), b, 1'b0);
  endtask

  task automatic do_read(input logic [15:0] ad [5], input int n, input bit hold);
    logic [127:0] b = '0;
    t0 = cyc;
    for (int k = 0; k < n; k++) begin
      put16(b, 2*k, ad[k]);
      push(KRD, ad[k], 8'h00, 2*k + 1, "R5 read strobe");
      push(KIB, 16'(k), smem[ad[k][7:0]], 2*k + 2, hold ? "R8 read under busy doorbell" : "R5 inbound byte");
    end
    push(KDN, 16'h0, 8'h00, 2*n + 1, "R7 read done");
    fire(8'hFF, 4'd1, 8'(2*n), b, hold);
  endtask

  task automatic do_rmw(input logic [15:0] ad, input logic [7:0] val, input logic [7:0] msk);
    logic [127:0] b = '0;
    logic [7:0] nv;
    t0 = cyc;
    put16(b, 0, ad);
    b[23:16] = val;
    b[31:24] = msk;
    nv = (smem[ad[7:0]] & ~msk) | (val & msk);
    push(KRD, ad, 8'h00, 1, "R6 rmw read");
    push(KWR, ad, nv, 2, "R6 rmw merged write");
    push(KDN, 16'h0, 8'h00, 3, "R7 rmw done");
    smem[ad[7:0]] = nv;
    fire(8'hFF, 4'd2, 8'd4, b, 1'b0);
  endtask

  task automatic do_err(input logic [7:0] ty, input logic [3:0] sb, input logic [7:0] sz,
                        input logic [7:0] code, input string tag);
    logic [127:0] b = {16{8'h5A}};
    t0 = cyc;
    push(KDN, 16'h1, code, 1, tag);
    fire(ty, sb, sz, b, 1'b0);
  endtask

  initial begin
    logic [15:0] ad [5];
    logic [7:0]  dt [5];
    ad = '{16'h12A0, 16'h3401, 16'hBE22, 16'h0043, 16'hFF64};
    dt = '{8'h11, 8'h92, 8'h3C, 8'hD4, 8'h7E};
    repeat (3) @(negedge clk);
    checks++;
    if (reg_en !== 1'b0 || ib_we !== 1'b0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: got en=%b ib=%b done=%b expected 0 0 0", reg_en, ib_we, done);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    do_write(ad, dt, 1);
    do_write(ad, dt, 3);
    do_write(ad, dt, 5);
    do_read(ad, 1, 1'b0);
    do_read(ad, 5, 1'b0);
    do_rmw(16'h7702, 8'hA5, 8'h0F);
    do_rmw(16'h3401, 8'h00, 8'hF0);
    do_read('{16'h7702, 16'h3401, 16'h0, 16'h0, 16'h0}, 2, 1'b0);
    do_read('{16'hBE22, 16'h0043, 16'h0, 16'h0, 16'h0}, 2, 1'b1);

    do_err(8'h10, 4'd0, 8'd3, 8'd3, "R1 wrong type");
    do_err(8'h00, 4'd7, 8'd0, 8'd3, "R1 type before sub");
    do_err(8'hFF, 4'd3, 8'd4, 8'd2, "R2 sub 3");
    do_err(8'hFF, 4'd15, 8'd0, 8'd2, "R2 sub 15 before size");
    do_err(8'hFF, 4'd0, 8'd7, 8'd1, "R3 write size 7");
    do_err(8'hFF, 4'd0, 8'd18, 8'd1, "R3 write six items");
    do_err(8'hFF, 4'd1, 8'd0, 8'd1, "R3 read size 0");
    do_err(8'hFF, 4'd1, 8'd12, 8'd1, "R3 read six items");
    do_err(8'hFF, 4'd1, 8'd5, 8'd1, "R3 read odd size");
    do_err(8'hFF, 4'd2, 8'd3, 8'd1, "R3 rmw size 3");

    // register contents untouched by rejected commands
    do_read('{16'h12A0, 16'hBE22, 16'hFF64, 16'h0, 16'h0}, 3, 1'b0);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7 missing events: got %0d pending expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule